// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned `W`-bit operands (default `W` = 8) by repeated conditional addition and right shift, producing a `2W`-bit result. A hardwired three-state sequencer drives a small register datapath. The datapath holds the multiplicand, an accumulator for the upper half of the result, the multiplier (which becomes the lower half as it shifts out), a one-bit carry and a down-counter that tracks the remaining steps.

A user writes the two operands through their own load strobes while the block reports ready. The user then pulses `start`. Every step of the operation takes two clock cycles. In the first, the multiplicand is added to the accumulator when the multiplier's lowest bit is 1. In the second, the combined carry, accumulator and multiplier are shifted right by one place as a single register, and the counter is decremented. After `W` steps the sequencer goes back to idle, raises `ready`, and the full product appears on `product`.

The asynchronous active-low reset is released synchronously inside the block. Reset clears every register and returns the sequencer to idle.

Top module: `seq_mult`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ready` is 1 and `product` is 0. This holds even when reset arrives in the middle of an operation.
- R2: While `ready` is 1, a cycle with `ld_mplier` high writes `mplier_in` into `product[W-1:0]` on the next clock edge. A cycle with `ld_mcand` high stores `mcand_in` as the multiplicand.
- R3: When `start` is high while `ready` is 1, `ready` falls on the next clock edge and `product[2W-1:W]` is cleared on that same edge.
- R4: After the edge that accepts `start`, `ready` stays 0 for exactly `2W` clock cycles and then returns to 1.
- R5: When `ready` returns to 1, `product` equals the unsigned product of the stored multiplicand and the stored multiplier.
- R6: While `ready` is 1 and no strobe or `start` is applied, `product` holds its value.
- R7: Load strobes applied while `ready` is 0 have no effect on the running operation or on its result.
- R8: A `start` pulse applied while `ready` is 0 has no effect: the timing and the result of the running operation are unchanged.
- R9: If `start` is held high when `ready` returns, a new operation begins on the next edge, after one ready cycle. That operation uses the old multiplicand and the low half of the previous product as its multiplier.
- R10: The carry out of each addition is shifted into the top accumulator bit, so all-ones times all-ones gives 2^(2W) - 2^(W+1) + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_mcand | input | 1 | Strobe to store the multiplicand (only while ready) |
| mcand_in | input | W | Multiplicand data |
| ld_mplier | input | 1 | Strobe to store the multiplier (only while ready) |
| mplier_in | input | W | Multiplier data |
| start | input | 1 | Begins an operation when sampled high while ready |
| ready | output | 1 | High while the sequencer is idle |
| product | output | 2W | Accumulator (upper half) joined with the multiplier register (lower half) |

## Verification
A start sampled at edge e0 shows up as `ready` low and a cleared upper half right after e0. The result, and `ready` high again, are due just after edge e0+2W. Operand loads show up on `product` one edge after the strobe. A reference model in the bench is advanced on every rising edge from the same inputs the design sees. The bench compares `ready` on every falling edge, and compares `product` on every falling edge where the model says idle. Directed tasks count the ready-low cycles between those falling edges, so the 2W-cycle window is checked exactly and no intermediate value is sampled.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;

  // Sequencer encoding; the next-state equations depend on these codes.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'b00,
    SEQ_ADD   = 2'b01,
    SEQ_SHIFT = 2'b10
  } seq_state_e;

  typedef struct packed {
    logic ld_b;   // store multiplicand
    logic ld_q;   // store multiplier
    logic init;   // clear accumulator, preset counter
    logic add;    // accumulate multiplicand, capture carry
    logic shift;  // shift carry/accumulator/multiplier, count down
    logic clr_c;  // clear carry
  } seq_ctrl_t;

endpackage

// File: rtl/seq_mult_rst_sync.sv
module seq_mult_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/seq_mult_ctrl.sv
module seq_mult_ctrl
  import seq_mult_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ld_mcand,
  input  logic       ld_mplier,
  input  logic       q_lsb,
  input  logic       cnt_zero,
  output seq_ctrl_t  ctl,
  output logic       ready,
  output logic [1:0] state
);
  seq_state_e state_q, state_d;
  logic is_idle, is_add, is_shift;
  logic nxt_m0, nxt_m1;

  // 2-to-4 decode; code 11 decodes to nothing
  assign is_idle  = (state_q == SEQ_IDLE);
  assign is_add   = (state_q == SEQ_ADD);
  assign is_shift = (state_q == SEQ_SHIFT);

  // Next-state equations; code 11 falls through to 00
  always_comb begin
    nxt_m0  = (is_idle & start) | (is_shift & ~cnt_zero);
    nxt_m1  = is_add;
    state_d = seq_state_e'({nxt_m1, nxt_m0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    ctl.ld_b  = is_idle & ld_mcand;
    ctl.ld_q  = is_idle & ld_mplier;
    ctl.init  = is_idle & start;
    ctl.add   = is_add & q_lsb;
    ctl.shift = is_shift;
    ctl.clr_c = (is_idle & start) | is_shift;
  end

  assign ready = is_idle;
  assign state = state_q;
endmodule

// File: rtl/seq_mult_cnt.sv
module seq_mult_cnt #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic dec,
  output logic zero
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam logic [PW-1:0] P_TOP = PW'(W - 1);

  logic [PW-1:0] p_q, p_d;
  logic          p_en;

  always_comb begin
    p_en = init | dec;
    p_d  = init ? P_TOP : (p_q - PW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    p_q <= '0;
    else if (p_en) p_q <= p_d;
  end

  // Zero detect on the value before the decrement
  assign zero = (p_q == '0);
endmodule

// File: rtl/seq_mult_dp.sv
module seq_mult_dp
  import seq_mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  seq_ctrl_t      ctl,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic           q_lsb,
  output logic [2*W-1:0] product
);
  logic [W-1:0] b_q, a_q, q_q;
  logic         c_q;
  logic [W-1:0] a_d, q_d;
  logic         c_d;
  logic         a_en, q_en, c_en;
  logic [W:0]   sum;

  assign sum = {1'b0, a_q} + {1'b0, b_q};

  always_comb begin
    a_en = ctl.init | ctl.add | ctl.shift;
    q_en = ctl.ld_q | ctl.shift;
    c_en = ctl.clr_c | ctl.add;
    a_d  = a_q;
    q_d  = q_q;
    c_d  = c_q;
    if (ctl.init)  a_d = '0;
    if (ctl.ld_q)  q_d = mplier_in;
    if (ctl.add)   {c_d, a_d} = sum;
    if (ctl.shift) {a_d, q_d} = {c_q, a_q, q_q[W-1:1]};
    if (ctl.clr_c) c_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      a_q <= '0;
      q_q <= '0;
      c_q <= 1'b0;
    end else begin
      if (ctl.ld_b) b_q <= mcand_in;
      if (a_en)     a_q <= a_d;
      if (q_en)     q_q <= q_d;
      if (c_en)     c_q <= c_d;
    end
  end

  assign q_lsb   = q_q[0];
  assign product = {a_q, q_q};
endmodule

// File: rtl/seq_mult.sv
module seq_mult
  import seq_mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_mcand,
  input  logic [W-1:0]   mcand_in,
  input  logic           ld_mplier,
  input  logic [W-1:0]   mplier_in,
  input  logic           start,
  output logic           ready,
  output logic [2*W-1:0] product
);
  logic      rst_sync_n;
  logic      q_lsb, cnt_zero;
  logic [1:0] state_w;
  seq_ctrl_t ctl;

  seq_mult_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  seq_mult_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .ld_mcand(ld_mcand), .ld_mplier(ld_mplier),
    .q_lsb(q_lsb), .cnt_zero(cnt_zero),
    .ctl(ctl), .ready(ready), .state(state_w)
  );

  seq_mult_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .init(ctl.init), .dec(ctl.shift), .zero(cnt_zero)
  );

  seq_mult_dp #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_sync_n), .ctl(ctl),
    .mcand_in(mcand_in), .mplier_in(mplier_in),
    .q_lsb(q_lsb), .product(product)
  );
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           ld_mcand,
  input logic           ld_mplier,
  input logic           ready,
  input logic [1:0]     state,
  input logic [2*W-1:0] product
);
  localparam int CW = $clog2(2 * W + 2);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (ready) busy_cnt <= '0;
    else            busy_cnt <= busy_cnt + CW'(1);
  end

  // R3
  start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start |=> !ready);

  // R3
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start |=> product[2*W-1:W] == '0);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_cnt == CW'(2 * W));

  // R4
  step_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'b01 |=> state == 2'b10);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !start && !ld_mcand && !ld_mplier |=> $stable(product));
endmodule

bind seq_mult seq_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start),
  .ld_mcand(ld_mcand), .ld_mplier(ld_mplier),
  .ready(ready), .state(state_w), .product(product)
);

// File: tb/sim_seq_mult.sv
module sim_seq_mult;
  localparam int W      = 8;
  localparam int CLK_NS = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ld_mcand, ld_mplier, start;
  logic [W-1:0]   mcand_in, mplier_in;
  logic           ready;
  logic [2*W-1:0] product;

  int n_chk = 0;
  int n_err = 0;
  int wd    = 0;
  bit model_on = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  seq_mult #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_mcand(ld_mcand), .mcand_in(mcand_in),
    .ld_mplier(ld_mplier), .mplier_in(mplier_in), .start(start),
    .ready(ready), .product(product)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  logic           m_ready;
  int             m_left;
  logic [W-1:0]   m_b;
  logic [2*W-1:0] m_prod, m_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready <= 1'b1; m_left <= 0; m_b <= '0; m_prod <= '0; m_res <= '0;
    end else if (m_ready) begin
      logic [W-1:0] nb, nq;
      nb = ld_mcand  ? mcand_in  : m_b;
      nq = ld_mplier ? mplier_in : m_prod[W-1:0];
      m_b <= nb;
      m_prod <= {m_prod[2*W-1:W], nq};
      if (start) begin
        m_ready <= 1'b0;
        m_left  <= 2 * W - 1;
        m_res   <= (2*W)'(nb) * (2*W)'(nq);
      end
    end else if (m_left == 0) begin
      m_ready <= 1'b1;
      m_prod  <= m_res;
    end else begin
      m_left <= m_left - 1;
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check(ready == m_ready, "R4 ready vs model", 64'(ready), 64'(m_ready));
      if (m_ready && ready)
        check(product == m_prod, "R5 idle product vs model", 64'(product), 64'(m_prod));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_err++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic wait_ready(output int cyc, input bit noise);
    cyc = 1;
    for (int k = 0; k < 4 * W; k++) begin
      @(negedge clk);
      if (ready) break;
      cyc++;
      if (noise && cyc < 2 * W - 2) begin
        ld_mcand = 1'b1; mcand_in = W'($urandom);
        ld_mplier = 1'b1; mplier_in = W'($urandom);
        start = 1'($urandom);
      end else begin
        ld_mcand = 1'b0; ld_mplier = 1'b0; start = 1'b0;
      end
    end
  endtask

  task automatic run_op(input logic [W-1:0] b, input logic [W-1:0] q,
                        input string tag, input bit noise);
    int cyc;
    logic [2*W-1:0] exp;
    exp = (2*W)'(b) * (2*W)'(q);
    @(negedge clk);
    ld_mcand = 1'b1; mcand_in = b; ld_mplier = 1'b1; mplier_in = q;
    @(negedge clk);
    ld_mcand = 1'b0; ld_mplier = 1'b0;
    check(product[W-1:0] == q, "R2 multiplier load", 64'(product[W-1:0]), 64'(q));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R3 ready falls", 64'(ready), 64'd0);
    check(product[2*W-1:W] == '0, "R3 accumulator cleared",
          64'(product[2*W-1:W]), 64'd0);
    wait_ready(cyc, noise);
    check(cyc == 2 * W, {tag, " busy length (R4)"}, 64'(cyc), 64'(2 * W));
    check(product == exp, {tag, " result (R5)"}, 64'(product), 64'(exp));
  endtask

  initial begin
    logic [2*W-1:0] p1, p2;
    int cyc;
    rst_n = 1'b0; ld_mcand = 1'b0; ld_mplier = 1'b0; start = 1'b0;
    mcand_in = '0; mplier_in = '0;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1 ready in reset", 64'(ready), 64'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;
    check(ready == 1'b1, "R1 ready after reset", 64'(ready), 64'd1);
    check(product == '0, "R1 product after reset", 64'(product), 64'd0);

    run_op(8'h00, 8'h00, "R5 zero*zero", 1'b0);
    run_op(8'h00, 8'hFF, "R5 zero*max", 1'b0);
    run_op(8'hFF, 8'h00, "R5 max*zero", 1'b0);
    run_op(8'h01, 8'h01, "R5 one*one", 1'b0);
    run_op(8'h01, 8'hFF, "R5 one*max", 1'b0);
    run_op(8'hFF, 8'h01, "R5 max*one", 1'b0);
    run_op(8'hFF, 8'hFF, "R10 carry max*max", 1'b0);
    check(product == 16'hFE01, "R10 carry constant", 64'(product), 64'h FE01);
    run_op(8'hAA, 8'h55, "R5 pattern", 1'b0);
    for (int i = 0; i < 20; i++) run_op(W'($urandom), W'($urandom), "R5 random", 1'b0);

    // R6: idle hold
    p1 = product;
    repeat (5) @(negedge clk);
    check(product == p1, "R6 idle hold", 64'(product), 64'(p1));
    check(ready == 1'b1, "R6 still ready", 64'(ready), 64'd1);

    // R7 and R8: strobes and start during busy
    run_op(8'hC3, 8'h7E, "R7 R8 noisy busy", 1'b1);
    run_op(8'h9B, 8'hE4, "R7 R8 noisy busy", 1'b1);

    // R9: start held across completion
    @(negedge clk);
    ld_mcand = 1'b1; mcand_in = 8'h35; ld_mplier = 1'b1; mplier_in = 8'hB7;
    @(negedge clk);
    ld_mcand = 1'b0; ld_mplier = 1'b0; start = 1'b1;
    @(negedge clk);
    wait_ready(cyc, 1'b0);
    start = 1'b1;
    p1 = 16'(8'h35) * 16'(8'hB7);
    check(product == p1, "R9 first result", 64'(product), 64'(p1));
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R9 restart without gap", 64'(ready), 64'd0);
    wait_ready(cyc, 1'b0);
    p2 = 16'(8'h35) * 16'(p1[W-1:0]);
    check(cyc == 2 * W, "R9 second busy length", 64'(cyc), 64'(2 * W));
    check(product == p2, "R9 second result", 64'(product), 64'(p2));

    // R1: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    model_on = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(ready == 1'b1, "R1 ready on mid-run reset", 64'(ready), 64'd1);
    check(product == '0, "R1 product on mid-run reset", 64'(product), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;
    run_op(8'h12, 8'h34, "R5 after reset", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule